// File: doc/BRIEF.md
# SDRAM Burst Splitter and Read Beat Filter

This block sits between an on-chip request port and an SDRAM command scheduler. It accepts one platform request at a time: an address, a byte count from 1 to 32, and a read/write flag. For each request it issues one or two full-length sequential bursts to the scheduler. The burst length is always 4 beats, except that 8 beats may be used when the memory is configured as DDR3. A short read still fetches a whole burst. The block counts every returned beat but forwards to the requester only the beats that cover the requested bytes.

When a request holds more bytes than one burst can carry, the block issues two back-to-back bursts. This is the case for a 32-byte access to DDR2 on a 32-bit bus. The second burst starts one burst size above the first, and the read data of both bursts comes back as one contiguous response. A write burst carries per-byte enables, so bytes outside the request are never modified. The request is acknowledged only once the whole sequence is finished. The write data path runs beside this block and is not shown.

The configuration has three inputs: a DDR3 select, an 8-beat preference, and a 32-bit bus select. A 32-bit bus gives 4 bytes per beat and a 64-bit bus gives 8. Request addresses are beat-aligned, and the configuration is held stable while a request is in flight.

Top module: `sdram_burst_splitter`

## Requirements
- R1: `cmd_bl8` is 1 (8-beat burst) only when `cfg_ddr3` and `cfg_bl8` are both 1 at request capture; otherwise every burst is 4 beats.
- R2: A read needing N beats (N = ceil(size / beat bytes)) that fits in one burst issues exactly one command. Only the first N returned beats appear on `rsp_valid`, `rsp_last` is 1 on the N-th, and the remaining beats of the burst are dropped.
- R3: When N exceeds the burst length, two commands are issued. The first is at the request address and the second at that address plus the burst size in bytes, which is 16 for DDR2 on a 32-bit bus.
- R4: The read data of a split access is forwarded in address order as one response of N beats, with `rsp_last` set only on the final beat of the second burst.
- R5: On a write command, `cmd_be` bit i (byte i of the burst, bit 0 = lowest address) is 1 exactly when that byte lies within the request. Bytes beyond the request and beyond the burst are 0. Read commands carry `cmd_be` all zero.
- R6: `req_ready` is a one-cycle acknowledge. For a write it is raised after the last command is accepted. For a read it is raised after every beat of every burst has been returned. No new request is taken until then.
- R7: While `cmd_valid` is high and `cmd_ready` is low, the command and its fields hold steady.
- R8: During and directly after reset, `cmd_valid`, `req_ready` and `rsp_valid` are 0.
- R9: With `cfg_bus32` = 0 (8 bytes per beat), a 32-byte 4-beat request fits in one burst, and all 4 returned beats are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ddr3 | input | 1 | Memory is DDR3 (1) or DDR2 (0) |
| cfg_bl8 | input | 1 | Prefer 8-beat bursts (honoured only with DDR3) |
| cfg_bus32 | input | 1 | 32-bit memory bus (1) or 64-bit (0) |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_ready | output | 1 | One-cycle completion acknowledge |
| req_write | input | 1 | Request is a write |
| req_addr | input | AW | Beat-aligned byte address |
| req_size | input | SW | Byte count, 1 to 32 |
| cmd_valid | output | 1 | Burst command valid |
| cmd_ready | input | 1 | Scheduler accepts command |
| cmd_write | output | 1 | Burst is a write |
| cmd_addr | output | AW | Burst start address |
| cmd_bl8 | output | 1 | Burst is 8 beats (else 4) |
| cmd_be | output | MAXB | Per-byte write enables of the burst |
| mem_rvalid | input | 1 | Read beat from memory |
| mem_rdata | input | DW | Read beat data |
| rsp_valid | output | 1 | Forwarded read beat |
| rsp_data | output | DW | Forwarded read data |
| rsp_last | output | 1 | Final beat of the response |

## Verification
The bench targets the split boundary: a 32-byte access on a 32-bit DDR2 bus versus the same access with 8-beat DDR3 bursts or on a 64-bit bus. A design with the wrong split test would issue one command too many or too few, or offset the second one wrongly. Single-beat reads with 4- and 8-beat bursts check the beat filter; a design that forwards the trailing beats or misplaces the last marker produces surplus response items. Partial writes check the byte enables, and an 8-beat request on DDR2 checks that the burst-length preference is ignored there. A premature acknowledge is caught by checking that every expected command and beat has already been consumed when `req_ready` appears.

// File: rtl/sdram_burst_splitter.sv
module sdram_burst_splitter #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int SW = 6,
  localparam int MAXB = 8 * (DW / 8)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_ddr3,
  input  logic            cfg_bl8,
  input  logic            cfg_bus32,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [SW-1:0]   req_size,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic            cmd_write,
  output logic [AW-1:0]   cmd_addr,
  output logic            cmd_bl8,
  output logic [MAXB-1:0] cmd_be,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            rsp_last
);

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_WAIT, S_ACK} state_t;

  state_t        st;
  logic [AW-1:0] a_q;
  logic [SW-1:0] sz_q;
  logic          wr_q, bl8_q, b32_q, sent_q;
  logic [7:0]    beats_q;

  logic [7:0] sz8, blen, bbytes, need, total, off;
  logic       split, beat_in, last_cmd;

  assign sz8    = 8'(sz_q);
  assign blen   = bl8_q ? 8'd8 : 8'd4;
  assign bbytes = b32_q ? (bl8_q ? 8'd32 : 8'd16) : (bl8_q ? 8'd64 : 8'd32);
  assign need   = b32_q ? ((sz8 + 8'd3) >> 2) : ((sz8 + 8'd7) >> 3);
  assign split  = need > blen;
  assign total  = split ? (blen << 1) : blen;
  assign off    = sent_q ? bbytes : 8'd0;
  assign last_cmd = !split || sent_q;

  assign beat_in   = mem_rvalid && !wr_q && (st == S_CMD || st == S_WAIT);
  assign rsp_valid = beat_in && (beats_q < need);
  assign rsp_data  = mem_rdata;
  assign rsp_last  = (beats_q == need - 8'd1);

  assign req_ready = (st == S_ACK);
  assign cmd_valid = (st == S_CMD);
  assign cmd_write = wr_q;
  assign cmd_bl8   = bl8_q;
  assign cmd_addr  = a_q + AW'(off);

  always_comb begin
    for (int i = 0; i < MAXB; i++)
      cmd_be[i] = wr_q && (8'(i) < bbytes) && ((off + 8'(i)) < sz8);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      sz_q    <= '0;
      wr_q    <= 1'b0;
      bl8_q   <= 1'b0;
      b32_q   <= 1'b0;
      sent_q  <= 1'b0;
      beats_q <= '0;
    end else begin
      if (beat_in) beats_q <= beats_q + 8'd1;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q     <= req_addr;
          sz_q    <= req_size;
          wr_q    <= req_write;
          bl8_q   <= cfg_ddr3 & cfg_bl8;
          b32_q   <= cfg_bus32;
          sent_q  <= 1'b0;
          beats_q <= '0;
          st      <= S_CMD;
        end
        S_CMD: if (cmd_ready) begin
          if (last_cmd) st <= wr_q ? S_ACK : S_WAIT;
          else          sent_q <= 1'b1;
        end
        S_WAIT: if (beat_in && beats_q == total - 8'd1) st <= S_ACK;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_burst_splitter_chk.sv
module sdram_burst_splitter_chk #(
  parameter int AW = 32,
  parameter int DW = 64,
  localparam int MAXB = 8 * (DW / 8)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_ddr3,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            cmd_write,
  input logic [AW-1:0]   cmd_addr,
  input logic            cmd_bl8,
  input logic [MAXB-1:0] cmd_be,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            mem_rvalid
);

  AST_BL8_NEEDS_DDR3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_bl8 |-> cfg_ddr3); // R1

  AST_RSP_FROM_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_rvalid); // R2

  AST_SPLIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid || (cmd_addr == $past(cmd_addr) + AW'(16))); // R3

  AST_READ_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write |-> cmd_be == '0); // R5

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready && !cmd_valid); // R6

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_be) && $stable(cmd_bl8)); // R7

endmodule

bind sdram_burst_splitter sdram_burst_splitter_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_sdram_burst_splitter.sv
module sim_sdram_burst_splitter;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int SW = 6;
  localparam int MAXB = 64;

  logic clk = 0, rst_n = 0;
  logic cfg_ddr3 = 0, cfg_bl8 = 0, cfg_bus32 = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic req_ready, cmd_valid, cmd_write, cmd_bl8, rsp_valid, rsp_last;
  logic cmd_ready = 0, mem_rvalid = 0;
  logic [AW-1:0] cmd_addr;
  logic [MAXB-1:0] cmd_be;
  logic [DW-1:0] mem_rdata = '0, rsp_data;

  int checks = 0, failures = 0;
  string cur_tag = "R8";

  logic [AW-1:0]   eq_addr[$];
  logic            eq_wr[$], eq_bl8[$];
  logic [MAXB-1:0] eq_be[$];
  logic [DW-1:0]   er_data[$];
  logic            er_last[$];
  logic [DW-1:0]   mq[$];
  int              cur_bb = 4, cur_blen = 4;

  always #5 clk = ~clk;

  sdram_burst_splitter #(.AW(AW), .DW(DW), .SW(SW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // scheduler and memory model
  int pc = 0;
  always @(posedge clk) begin
    #1;
    pc++;
    cmd_ready <= (pc % 3 != 1);
    if (mq.size() > 0 && pc % 4 != 2) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mq.pop_front();
    end else mem_rvalid <= 1'b0;
  end

  // monitor
  logic            prev_stall = 0;
  logic [AW-1:0]   prev_addr = '0;
  always @(negedge clk) if (rst_n) begin
    if (prev_stall)
      chk(cmd_valid && cmd_addr == prev_addr, "R7",
          $sformatf("held cmd actual v=%0b a=%h expected v=1 a=%h", cmd_valid, cmd_addr, prev_addr));
    prev_stall = cmd_valid && !cmd_ready;
    prev_addr  = cmd_addr;
    if (cmd_valid && cmd_ready) begin
      if (eq_addr.size() == 0)
        chk(0, cur_tag, $sformatf("extra cmd actual a=%h expected none", cmd_addr));
      else begin
        logic [AW-1:0] ea; logic ew, eb; logic [MAXB-1:0] ebe;
        ea = eq_addr.pop_front(); ew = eq_wr.pop_front();
        eb = eq_bl8.pop_front(); ebe = eq_be.pop_front();
        chk(cmd_addr == ea && cmd_write == ew && cmd_bl8 == eb && cmd_be == ebe, cur_tag,
            $sformatf("cmd actual a=%h w=%0b bl8=%0b be=%h expected a=%h w=%0b bl8=%0b be=%h",
                      cmd_addr, cmd_write, cmd_bl8, cmd_be, ea, ew, eb, ebe));
      end
      if (!cmd_write)
        for (int k = 0; k < cur_blen; k++) begin
          logic [31:0] a;
          a = cmd_addr + 32'(k * cur_bb);
          mq.push_back({~a, a});
        end
    end
    if (rsp_valid) begin
      if (er_data.size() == 0)
        chk(0, cur_tag, $sformatf("extra beat actual d=%h expected none", rsp_data));
      else begin
        logic [DW-1:0] ed; logic el;
        ed = er_data.pop_front(); el = er_last.pop_front();
        chk(rsp_data == ed && rsp_last == el, cur_tag,
            $sformatf("beat actual d=%h last=%0b expected d=%h last=%0b", rsp_data, rsp_last, ed, el));
      end
    end
  end

  task automatic do_req(input logic [AW-1:0] addr, input int size, input bit wr,
                        input bit ddr3, input bit bl8, input bit b32, input string tag);
    int bb, blen, bbytes, need, nb;
    bit eb8;
    eb8 = ddr3 && bl8;
    bb = b32 ? 4 : 8;
    blen = eb8 ? 8 : 4;
    bbytes = bb * blen;
    need = (size + bb - 1) / bb;
    nb = (need > blen) ? 2 : 1;
    cur_tag = tag; cur_bb = bb; cur_blen = blen;
    for (int j = 0; j < nb; j++) begin
      logic [MAXB-1:0] be;
      be = '0;
      for (int i = 0; i < MAXB; i++) be[i] = wr && (i < bbytes) && (j * bbytes + i < size);
      eq_addr.push_back(addr + 32'(j * bbytes));
      eq_wr.push_back(wr); eq_bl8.push_back(eb8); eq_be.push_back(be);
    end
    if (!wr)
      for (int i = 0; i < need; i++) begin
        logic [31:0] a;
        a = addr + 32'(i * bb);
        er_data.push_back({~a, a});
        er_last.push_back(i == need - 1);
      end
    @(posedge clk); #1;
    cfg_ddr3 = ddr3; cfg_bl8 = bl8; cfg_bus32 = b32;
    req_addr = addr; req_size = SW'(size); req_write = wr; req_valid = 1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    chk(eq_addr.size() == 0 && er_data.size() == 0 && mq.size() == 0, "R6",
        $sformatf("ack early actual pending cmd=%0d rsp=%0d mem=%0d expected 0 0 0",
                  eq_addr.size(), er_data.size(), mq.size()));
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk(!req_ready, "R6", $sformatf("ack width actual req_ready=%0b expected 0", req_ready));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !req_ready && !rsp_valid, "R8",
        $sformatf("in reset actual %0b%0b%0b expected 000", cmd_valid, req_ready, rsp_valid));
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(!cmd_valid && !req_ready && !rsp_valid, "R8",
        $sformatf("after reset actual %0b%0b%0b expected 000", cmd_valid, req_ready, rsp_valid));

    do_req(32'h0000_1000, 4,  0, 0, 0, 1, "R2");  // 1 beat of 4
    do_req(32'h0000_2040, 3,  0, 1, 1, 1, "R1");  // 1 beat of 8
    do_req(32'h0000_3000, 12, 0, 0, 1, 1, "R1");  // bl8 ignored on DDR2
    do_req(32'h0000_4000, 32, 0, 0, 0, 1, "R3");  // split read
    do_req(32'h0000_4800, 20, 0, 0, 0, 1, "R4");  // split read, partial
    do_req(32'h0000_5000, 32, 1, 0, 0, 1, "R5");  // split write
    do_req(32'h0000_6000, 6,  1, 0, 0, 1, "R5");  // partial write
    do_req(32'h0000_7000, 32, 0, 0, 0, 0, "R9");  // 64-bit, one burst
    do_req(32'h0000_8000, 20, 1, 1, 0, 0, "R5");  // 64-bit partial write
    do_req(32'h0000_9000, 32, 0, 1, 1, 1, "R1");  // DDR3 bl8, no split
    do_req(32'h0000_A000, 12, 0, 1, 1, 0, "R2");  // 2 of 8 beats, 64-bit
    do_req(32'h0000_B000, 32, 0, 1, 0, 1, "R3");  // DDR3 bl4 split
    do_req(32'h0000_C000, 17, 1, 1, 1, 1, "R5");  // bl8 partial write

    repeat (10) @(negedge clk);
    chk(eq_addr.size() == 0 && er_data.size() == 0, "R2",
        $sformatf("leftover actual cmd=%0d rsp=%0d expected 0 0", eq_addr.size(), er_data.size()));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule